// File: doc/BRIEF.md
# Reference-Switch Phase Offset Corrector

This block keeps the phase offset that turns a selected timing reference into a virtual reference for a downstream phase-locked loop. Each time the reference changes, the phase step measured at that change is added to a stored offset. The loop therefore sees a continuous reference, and the offset becomes the running sum of every switch error. The offset is held modulo the 125 us frame period, in a signed window centred on zero.

The offset is cleared through an active-low clear pin. A low pulse counts only if it lasts for a minimum number of consecutive clock samples. An accepted pulse does not zero the offset at once. It starts a slew in which every 125 us frame tick moves the offset one fixed step towards zero. Because the stored value is always the wrapped representative, moving towards zero is also the shorter way around the frame. When the last step lands exactly on zero, a done flag pulses. Phase is counted in fixed-point units: 2^FRAC_BITS units per 50 ns clock period. One step is 5 ns in those units (2 units at the defaults).

The controller has two states. `ST_HOLD` keeps the offset and only adds switch errors. `ST_SLEW` adds switch errors and steps on frame ticks. The transition HOLD→SLEW ("clear accepted") fires on the sample that completes the minimum low run. The transition SLEW→HOLD ("landed") fires on a frame tick whose step reaches zero. A synchronous reset forces HOLD with a zero offset.

Top module: `phase_offset_corrector`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `ofs_out` = 0 and `walk_done` = 0, and any slew in progress is abandoned, so later frame ticks leave the offset unchanged.
- R2: On a clock edge where `ref_sw_stb` is high, `ref_sw_err` is added to the offset. `ref_sw_err` must lie in [-HALF, HALF), where HALF = 20000 units at the defaults. If the sum leaves that window, it is brought back by adding or subtracting the frame period of 40000 units. The result is visible on `ofs_out` in the next cycle.
- R3: A clear is accepted on the 6th consecutive clock edge at which `clr_n` is sampled low. A low run of 5 or fewer edges is ignored: frame ticks afterwards do not move the offset. A longer low run starts only one slew.
- R4: Frame ticks while no slew is active leave the offset unchanged.
- R5: During a slew, each frame tick moves the offset by exactly 2 units towards zero. A positive offset decreases and a negative one increases. This includes a negative value produced by wrapping a large positive sum.
- R6: If a tick arrives during a slew when the offset magnitude is at most 2 units, the offset becomes exactly 0. `walk_done` is then high for exactly one cycle, in the same cycle that first shows the zero, and the slew ends.
- R7: A switch strobe during a slew is added to the offset and the slew continues. When a strobe and a tick share an edge, the error is added first and the step is taken from the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_sw_stb | input | 1 | One-cycle strobe marking a reference switch |
| ref_sw_err | input | OFS_W (16) | Signed phase error measured at the switch, in phase units |
| clr_n | input | 1 | Active-low offset clear request, synchronous to clk |
| frame_tick | input | 1 | One-cycle pulse every 125 us frame |
| ofs_out | output | OFS_W (16) | Signed phase offset currently applied |
| walk_done | output | 1 | One-cycle pulse when a slew lands on zero |

## Verification
The hardest case to reach is a slew taking the short way across the frame boundary. This needs an offset that has wrapped, and no single legal error can produce one. The bench therefore issues two large positive switch errors, whose sum exceeds half a frame and is stored as a negative value, then runs thousands of back-to-back ticks until it lands. A second awkward case is a strobe and a tick on the same edge, mid-slew. The bench forces this explicitly and compares the result against its behavioural model.

// File: rtl/pofs_pkg.sv
package pofs_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_SLEW = 1'b1
    } pofs_state_e;
endpackage

// File: rtl/pofs_clear_qual.sv
// Qualifies the active-low clear pin: accept fires on the sample that
// completes MIN_LOW consecutive low samples, once per low run.
module pofs_clear_qual #(
    parameter int MIN_LOW = 6,
    localparam int CW = $clog2(MIN_LOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    output logic accept
);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (clr_n) begin
            low_cnt <= '0;
        end else if (low_cnt < CW'(MIN_LOW)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign accept = !clr_n && (low_cnt == CW'(MIN_LOW - 1));
endmodule

// File: rtl/pofs_wrap_add.sv
// Adds two phase values and folds the result into [-HALF, HALF).
module pofs_wrap_add #(
    parameter int OFS_W = 16,
    parameter int FRAME_UNITS = 40000,
    localparam int HALF = FRAME_UNITS / 2
) (
    input  logic signed [OFS_W-1:0] a,
    input  logic signed [OFS_W-1:0] b,
    output logic signed [OFS_W-1:0] y
);
    localparam logic signed [OFS_W:0] HI_S  = (OFS_W+1)'(HALF);
    localparam logic signed [OFS_W:0] LO_S  = -(OFS_W+1)'(HALF);
    localparam logic signed [OFS_W:0] FRM_S = (OFS_W+1)'(FRAME_UNITS);

    logic signed [OFS_W:0] raw;
    logic signed [OFS_W:0] folded;

    always_comb begin
        raw = {a[OFS_W-1], a} + {b[OFS_W-1], b};
        if (raw >= HI_S) begin
            folded = raw - FRM_S;
        end else if (raw < LO_S) begin
            folded = raw + FRM_S;
        end else begin
            folded = raw;
        end
        y = folded[OFS_W-1:0];
    end
endmodule

// File: rtl/pofs_slew_step.sv
// One bounded step toward zero; lands exactly on zero when within one step.
module pofs_slew_step #(
    parameter int OFS_W = 16,
    parameter int STEP = 2
) (
    input  logic signed [OFS_W-1:0] cur,
    output logic signed [OFS_W-1:0] nxt,
    output logic                    land
);
    localparam logic signed [OFS_W-1:0] POS_S = OFS_W'(STEP);
    localparam logic signed [OFS_W-1:0] NEG_S = -OFS_W'(STEP);

    always_comb begin
        land = 1'b0;
        if (cur > POS_S) begin
            nxt = cur - POS_S;
        end else if (cur < NEG_S) begin
            nxt = cur + POS_S;
        end else begin
            nxt  = '0;
            land = 1'b1;
        end
    end
endmodule

// File: rtl/phase_offset_corrector.sv
module phase_offset_corrector
    import pofs_pkg::*;
#(
    parameter int CLK_NS = 50,
    parameter int FRAC_BITS = 4,
    parameter int FRAME_CLKS = 2500,
    parameter int MIN_LOW_NS = 300,
    parameter int STEP_NS = 5,
    localparam int UNITS_PER_CLK = 1 << FRAC_BITS,
    localparam int FRAME_UNITS = FRAME_CLKS * UNITS_PER_CLK,
    localparam int HALF = FRAME_UNITS / 2,
    localparam int OFS_W = $clog2(HALF) + 1,
    localparam int STEP = (STEP_NS * UNITS_PER_CLK + CLK_NS / 2) / CLK_NS,
    localparam int MIN_LOW = (MIN_LOW_NS + CLK_NS - 1) / CLK_NS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_sw_stb,
    input  logic signed [OFS_W-1:0] ref_sw_err,
    input  logic                    clr_n,
    input  logic                    frame_tick,
    output logic signed [OFS_W-1:0] ofs_out,
    output logic                    walk_done
);
    localparam logic signed [OFS_W-1:0] STEP_S = OFS_W'(STEP);
    localparam logic signed [OFS_W-1:0] HALF_S = OFS_W'(HALF);

    pofs_state_e state_q, state_n;
    logic signed [OFS_W-1:0] ofs_q, ofs_n;
    logic signed [OFS_W-1:0] add_err, sum, stepped;
    logic done_q, done_n;
    logic accept, land;

    assign add_err = ref_sw_stb ? ref_sw_err : '0;

    pofs_clear_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .accept (accept)
    );

    pofs_wrap_add #(.OFS_W(OFS_W), .FRAME_UNITS(FRAME_UNITS)) u_wrap (
        .a (ofs_q),
        .b (add_err),
        .y (sum)
    );

    pofs_slew_step #(.OFS_W(OFS_W), .STEP(STEP)) u_step (
        .cur  (sum),
        .nxt  (stepped),
        .land (land)
    );

    // State transitions: HOLD->SLEW on clear accepted, SLEW->HOLD on landed.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD: if (accept) state_n = ST_SLEW;
            ST_SLEW: if (frame_tick && land) state_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_n;
    end

    // Output datapath: errors always accumulate, steps only while slewing.
    always_comb begin
        ofs_n  = sum;
        done_n = 1'b0;
        if (state_q == ST_SLEW && frame_tick) begin
            ofs_n  = stepped;
            done_n = land;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q  <= '0;
            done_q <= 1'b0;
        end else begin
            ofs_q  <= ofs_n;
            done_q <= done_n;
        end
    end

    assign ofs_out   = ofs_q;
    assign walk_done = done_q;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ofs_q == '0 && !done_q && state_q == ST_HOLD));

    a_r2_in_window: assert property (@(posedge clk) disable iff (rst)
        (ofs_q >= -HALF_S) && (ofs_q < HALF_S));

    a_r3_no_start_while_high: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && clr_n) |=> (state_q == ST_HOLD));

    a_r4_hold_keeps_offset: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !ref_sw_stb) |=> $stable(ofs_q));

    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEW && frame_tick && !ref_sw_stb && ofs_q > STEP_S)
        |=> (ofs_q == $past(ofs_q) - STEP_S));

    a_r6_done_at_zero: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> (ofs_out == '0 && state_q == ST_HOLD));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);
endmodule

// File: tb/sim_phase_offset_corrector.sv
module sim_phase_offset_corrector;
    localparam int PERIOD = 50;
    localparam int FRAME  = 40000;
    localparam int HALFF  = 20000;
    localparam int STEPU  = 2;
    localparam int NLOW   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic signed [15:0] err = '0;
    logic clr_n = 1'b1;
    logic tick = 1'b0;
    logic signed [15:0] ofs;
    logic done;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    string cur_req = "R1";

    int m_ofs = 0;
    bit m_walk = 1'b0;
    int m_low = 0;
    bit m_done = 1'b0;

    phase_offset_corrector u0 (
        .clk(clk), .rst(rst), .ref_sw_stb(stb), .ref_sw_err(err),
        .clr_n(clr_n), .frame_tick(tick), .ofs_out(ofs), .walk_done(done)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_ofs = 0; m_walk = 0; m_low = 0; m_done = 0;
        end else begin
            int v;
            bit acc;
            acc = !clr_n && (m_low == NLOW - 1);
            if (clr_n) m_low = 0;
            else if (m_low < NLOW) m_low++;
            v = m_ofs + (stb ? int'(err) : 0);
            if (v >= HALFF) v -= FRAME;
            else if (v < -HALFF) v += FRAME;
            m_done = 0;
            if (m_walk && tick) begin
                if (v > STEPU) v -= STEPU;
                else if (v < -STEPU) v += STEPU;
                else begin v = 0; m_done = 1; m_walk = 0; end
            end else if (!m_walk && acc) begin
                m_walk = 1;
            end
            m_ofs = v;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (int'(ofs) !== m_ofs || done !== m_done) begin
                errors++;
                $display("FAIL %s cycle-compare: ofs=%0d done=%0b expected ofs=%0d done=%0b",
                         cur_req, int'(ofs), done, m_ofs, m_done);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input int e);
        stb = 1'b1; err = 16'(e);
        @(negedge clk);
        stb = 1'b0; err = '0;
    endtask

    task automatic clear(input int lows);
        clr_n = 1'b0;
        cyc(lows);
        clr_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        cyc(n);
        tick = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk);
        live = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        chk("R1 reset offset", int'(ofs), 0);
        chk("R1 reset done", int'(done), 0);

        // R2: accumulation and wrap
        cur_req = "R2";
        strobe(1000);  chk("R2 add", int'(ofs), 1000);
        strobe(-300);  chk("R2 add negative", int'(ofs), 700);
        strobe(19000); chk("R2 near edge", int'(ofs), 19700);
        strobe(500);   chk("R2 wrap high", int'(ofs), -19800);
        strobe(-500);  chk("R2 wrap low", int'(ofs), 19700);

        // R4: ticks with no slew
        cur_req = "R4";
        ticks(10);
        chk("R4 idle ticks", int'(ofs), 19700);

        // R3: short clear ignored, long clear starts one slew
        cur_req = "R3";
        do_reset();
        strobe(40);
        clear(NLOW - 1);
        ticks(5);
        chk("R3 short pulse ignored", int'(ofs), 40);
        clear(NLOW + 4);
        ticks(19);
        chk("R3 long pulse slews", int'(ofs), 2);
        ticks(1);
        chk("R3 landed", int'(ofs), 0);
        chk("R6 done after long pulse", int'(done), 1);
        ticks(3);
        chk("R3 single slew per pulse", int'(ofs), 0);

        // R5: short path after a wrap, many ticks
        cur_req = "R5";
        strobe(15000);
        strobe(10000);
        chk("R2 two-error wrap", int'(ofs), -15000);
        clear(NLOW);
        ticks(3);
        chk("R5 moves up from negative", int'(ofs), -14994);
        ticks(7496);
        chk("R5 last step pending", int'(ofs), -2);
        chk("R6 no early done", int'(done), 0);
        ticks(1);
        chk("R6 lands on zero", int'(ofs), 0);
        chk("R6 done pulse", int'(done), 1);
        cyc(1);
        chk("R6 done one cycle", int'(done), 0);

        // R6: odd offset lands exactly on zero
        cur_req = "R6";
        strobe(7);
        clear(NLOW);
        ticks(3);
        chk("R6 odd remainder", int'(ofs), 1);
        chk("R6 not yet done", int'(done), 0);
        ticks(1);
        chk("R6 odd lands", int'(ofs), 0);
        chk("R6 odd done", int'(done), 1);

        // R7: strobe during slew, including same edge as a tick
        cur_req = "R7";
        strobe(100);
        clear(NLOW);
        ticks(1);
        chk("R7 first step", int'(ofs), 98);
        stb = 1'b1; err = 16'sd50; tick = 1'b1;
        @(negedge clk);
        stb = 1'b0; err = '0; tick = 1'b0;
        chk("R7 add then step", int'(ofs), 146);
        strobe(-20);
        chk("R7 strobe alone mid-slew", int'(ofs), 126);
        ticks(62);
        chk("R7 slew continues", int'(ofs), 2);
        ticks(1);
        chk("R7 lands", int'(ofs), 0);
        chk("R7 done", int'(done), 1);

        // R1: reset aborts a slew
        cur_req = "R1";
        strobe(300);
        clear(NLOW);
        ticks(2);
        chk("R1 mid-slew value", int'(ofs), 296);
        do_reset();
        chk("R1 reset zeroes", int'(ofs), 0);
        strobe(10);
        ticks(5);
        chk("R1 slew abandoned", int'(ofs), 10);

        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule